// File: doc/BRIEF.md
# Registered DIMM Control-Word Sequencer

This block programs the buffer control words of registered DDR3 modules after power-up, one module slot at a time, with no software between the commands. A start pulse launches either a full initialisation pass or a short frequency-change pass. The full pass waits a start delay and a PLL-lock delay. It then walks every populated slot and sends control words 0 through 15, leaving out words 6 and 7, with a programmable gap before each word. It closes with a stabilisation delay. The frequency-change pass sends only the speed word, word 10, to each populated slot.

Each command is presented as a chip-select pair mask, a 3-bit bank field and a low address field that together carry the 4-bit word number and the 4-bit word value. A level send flag is raised with the command fields. The command-issue logic downstream acknowledges it, and the sequencer then drops the flag. If no acknowledge arrives within a programmable limit, the pass is abandoned and an error is flagged. All configuration inputs are expected to stay stable while the block is busy.

Top module: `rcw_ctlword_seq`

## Requirements
- R1: Slots are visited in ascending order. Slot s (s = 0..7) is populated when either bit 2s or bit 2s+1 of `cs_present_i` is set. Its commands drive `cmd_cs_o` = 2'b11 shifted left by 2s. Unpopulated slots produce no command.
- R2: In initialisation mode (`freq_mode_i` = 0), each populated slot receives words 0,1,2,3,4,5,8,9,10,11,12,13,14,15 in that order. Words 6 and 7 are never sent.
- R3: Word values, each 4 bits:
  - word 0 = 0x2
  - word 1 = 0xC if the slot's `single_rank_i` bit is set, else 0x0
  - words 2, 3, 4, 5 and 8 = nibble s of `rc2_i`, `rc3_i`, `rc4_i`, `rc5_i` and `rc8_i` (bits 4s+3:4s)
  - word 9 = 0xD
  - word 11 = `vdd_code_i`
  - every other word = 0x0
- R4: For word number w and value v, `cmd_bank_o` = {w[3], v[3], v[2]}. `cmd_addr_o` bits 4:3 = v[1:0] and bits 2:0 = w[2:0]. All higher address bits are 0.
- R5: `send_o` rises in the same cycle as the command fields. It and the fields stay unchanged until `ack_i` is sampled high, and `send_o` is low in the cycle after that.
- R6: In initialisation mode, the first command comes at least `dly_start_i`+`dly_pll_i`+`dly_word_i` cycles after the start pulse. Consecutive commands are more than `dly_word_i` cycles apart. `done_o` comes at least `dly_stab_i` cycles after the last command ends.
- R7: In frequency-change mode (`freq_mode_i` = 1), each populated slot receives only word 10. Its value is 0, 1, 2, 3 or 4 for `speed_i` codes 1, 2, 3, 4, 5, which stand for 800, 1066, 1333, 1600 and 1866 MT/s.
- R8: In frequency-change mode with `speed_i` equal to 0, 6 or 7, no command is sent, `err_speed_o` is set, and the pass ends with `done_o`.
- R9: If `send_o` stays high for more than `tmo_lim_i` cycles without `ack_i`, it drops, `err_tmo_o` is set, no further command is sent, and the pass ends with `done_o`.
- R10: `start_i` is taken only while idle. `busy_o` is high from the cycle after the start until `done_o`. `done_o` lasts one cycle. Both error flags clear at the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| freq_mode_i | input | 1 | 0 = full initialisation, 1 = speed word only |
| cs_present_i | input | 16 | Chip-select present mask |
| single_rank_i | input | 8 | Per-slot single-rank flag |
| rc2_i | input | 32 | Per-slot word 2 values, nibble per slot |
| rc3_i | input | 32 | Per-slot word 3 values |
| rc4_i | input | 32 | Per-slot word 4 values |
| rc5_i | input | 32 | Per-slot word 5 values |
| rc8_i | input | 32 | Per-slot word 8 values |
| vdd_code_i | input | 4 | Encoded supply voltage, sent as word 11 |
| speed_i | input | 3 | Speed grade code |
| dly_start_i | input | 16 | Start delay in cycles |
| dly_pll_i | input | 16 | PLL-lock delay in cycles |
| dly_word_i | input | 16 | Delay before each word in cycles |
| dly_stab_i | input | 16 | Stabilisation delay in cycles |
| tmo_lim_i | input | 16 | Acknowledge timeout in cycles |
| ack_i | input | 1 | Command accepted by the issue logic |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle end-of-pass pulse |
| err_speed_o | output | 1 | Unsupported speed code seen |
| err_tmo_o | output | 1 | Acknowledge timeout occurred |
| send_o | output | 1 | Command valid, waiting for acknowledge |
| cmd_cs_o | output | 16 | Chip-select pair mask of the command |
| cmd_bank_o | output | 3 | Bank field of the command |
| cmd_addr_o | output | 16 | Address field of the command |

## Verification
Some properties are checked on every cycle:
- while a command is pending, it names exactly one chip-select pair, never carries word 6 or 7, and keeps its upper address bits at zero;
- the send flag and the fields hold until the acknowledge, and the flag drops after an acknowledge or a timeout;
- the done pulse lasts one cycle, and no command is pending while idle or while an error flag is set.

Only the bench scenarios can show the rest: which slots are visited and in what order, the word sequence and values for given configurations (single-rank, voltage, per-slot values, speed mapping), the minimum spacing set by the programmed delays, and that a timeout stops the pass after its first command.

// File: rtl/rcw_pkg.sv
package rcw_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_DSTART, S_DPLL, S_SLOT, S_DWORD,
    S_SEND, S_ACK, S_NEXT, S_DSTAB, S_FIN
  } seq_state_e;

  localparam logic [3:0] SPEED_WORD = 4'd10;

  function automatic logic [3:0] rcw_value(input logic [3:0] w, input logic sr,
                                           input logic [3:0] v2, input logic [3:0] v3,
                                           input logic [3:0] v4, input logic [3:0] v5,
                                           input logic [3:0] v8, input logic [3:0] vdd);
    logic [3:0] r;
    case (w)
      4'd0:    r = 4'h2;
      4'd1:    r = sr ? 4'hC : 4'h0;
      4'd2:    r = v2;
      4'd3:    r = v3;
      4'd4:    r = v4;
      4'd5:    r = v5;
      4'd8:    r = v8;
      4'd9:    r = 4'hD;
      4'd11:   r = vdd;
      default: r = 4'h0;
    endcase
    return r;
  endfunction

  function automatic logic [2:0] rcw_bank(input logic [3:0] w, input logic [3:0] v);
    return {w[3], v[3], v[2]};
  endfunction

  function automatic logic [4:0] rcw_addr_lo(input logic [3:0] w, input logic [3:0] v);
    return {v[1:0], w[2:0]};
  endfunction

  function automatic logic speed_ok(input logic [2:0] s);
    return (s >= 3'd1) && (s <= 3'd5);
  endfunction

  function automatic logic [3:0] speed_value(input logic [2:0] s);
    logic [2:0] d;
    d = s - 3'd1;
    return {1'b0, d};
  endfunction

  function automatic logic word_skipped(input logic [3:0] w);
    return (w == 4'd6) || (w == 4'd7);
  endfunction

endpackage

// File: rtl/rcw_delay_timer.sv
module rcw_delay_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q, lim_q;
  logic             run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= '0;
      lim_q <= lim_i;
      run_q <= 1'b1;
    end else if (run_q && (cnt_q != lim_q)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = run_q && (cnt_q == lim_q);

  AST_TMR_NO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q <= lim_q)); // R6
endmodule

// File: rtl/rcw_cmd_issue.sv
module rcw_cmd_issue #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic             ack_i,
  input  logic [CNT_W-1:0] tmo_lim_i,
  output logic             send_o,
  output logic             ok_o,
  output logic             tmo_o
);
  logic [CNT_W-1:0] wait_q;
  logic             send_q;

  assign ok_o   = send_q && ack_i;
  assign tmo_o  = send_q && !ack_i && (wait_q == tmo_lim_i);
  assign send_o = send_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      send_q <= 1'b0;
      wait_q <= '0;
    end else if (fire_i) begin
      send_q <= 1'b1;
      wait_q <= '0;
    end else if (ok_o || tmo_o) begin
      send_q <= 1'b0;
      wait_q <= '0;
    end else if (send_q) begin
      wait_q <= wait_q + 1'b1;
    end
  end

  AST_SEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (send_o && !ack_i && !tmo_o) |=> send_o); // R5
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ok_o |=> !send_o); // R5
  AST_TMO_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_o |=> !send_o); // R9
endmodule

// File: rtl/rcw_word_map.sv
module rcw_word_map #(
  parameter int SLOTS  = 8,
  parameter int SLOT_W = 3,
  parameter int ADDR_W = 16
) (
  input  logic [SLOT_W-1:0]  slot_i,
  input  logic [3:0]         word_i,
  input  logic               freq_i,
  input  logic [2:0]         speed_i,
  input  logic [SLOTS-1:0]   single_rank_i,
  input  logic [4*SLOTS-1:0] rc2_i,
  input  logic [4*SLOTS-1:0] rc3_i,
  input  logic [4*SLOTS-1:0] rc4_i,
  input  logic [4*SLOTS-1:0] rc5_i,
  input  logic [4*SLOTS-1:0] rc8_i,
  input  logic [3:0]         vdd_i,
  output logic [2*SLOTS-1:0] cs_o,
  output logic [2:0]         bank_o,
  output logic [ADDR_W-1:0]  addr_o
);
  import rcw_pkg::*;

  logic [3:0] w_eff, v_eff;

  for (genvar g = 0; g < SLOTS; g++) begin : g_cs
    assign cs_o[2*g +: 2] = (slot_i == SLOT_W'(g)) ? 2'b11 : 2'b00;
  end

  always_comb begin
    if (freq_i) begin
      w_eff = SPEED_WORD;
      v_eff = speed_value(speed_i);
    end else begin
      w_eff = word_i;
      v_eff = rcw_value(word_i, single_rank_i[slot_i],
                        rc2_i[4*slot_i +: 4], rc3_i[4*slot_i +: 4],
                        rc4_i[4*slot_i +: 4], rc5_i[4*slot_i +: 4],
                        rc8_i[4*slot_i +: 4], vdd_i);
    end
    addr_o      = '0;
    addr_o[4:0] = rcw_addr_lo(w_eff, v_eff);
    bank_o      = rcw_bank(w_eff, v_eff);
  end
endmodule

// File: rtl/rcw_ctlword_seq.sv
module rcw_ctlword_seq #(
  parameter int CS_N   = 16,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  localparam int SLOTS  = CS_N / 2,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               freq_mode_i,
  input  logic [CS_N-1:0]    cs_present_i,
  input  logic [SLOTS-1:0]   single_rank_i,
  input  logic [4*SLOTS-1:0] rc2_i,
  input  logic [4*SLOTS-1:0] rc3_i,
  input  logic [4*SLOTS-1:0] rc4_i,
  input  logic [4*SLOTS-1:0] rc5_i,
  input  logic [4*SLOTS-1:0] rc8_i,
  input  logic [3:0]         vdd_code_i,
  input  logic [2:0]         speed_i,
  input  logic [CNT_W-1:0]   dly_start_i,
  input  logic [CNT_W-1:0]   dly_pll_i,
  input  logic [CNT_W-1:0]   dly_word_i,
  input  logic [CNT_W-1:0]   dly_stab_i,
  input  logic [CNT_W-1:0]   tmo_lim_i,
  input  logic               ack_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_speed_o,
  output logic               err_tmo_o,
  output logic               send_o,
  output logic [CS_N-1:0]    cmd_cs_o,
  output logic [2:0]         cmd_bank_o,
  output logic [ADDR_W-1:0]  cmd_addr_o
);
  import rcw_pkg::*;

  seq_state_e        st, st_nxt;
  logic [SLOT_W-1:0] slot_q;
  logic [3:0]        word_q;
  logic              freq_q;
  logic              busy_q, done_q, err_spd_q, err_tmo_q;
  logic [CS_N-1:0]   cs_q;
  logic [2:0]        bank_q;
  logic [ADDR_W-1:0] addr_q;

  logic              tmr_load, tmr_exp;
  logic [CNT_W-1:0]  tmr_lim;
  logic              iss_fire, iss_ok, iss_tmo;
  logic              slot_active, slot_last, word_last;
  logic [CS_N-1:0]   map_cs;
  logic [2:0]        map_bank;
  logic [ADDR_W-1:0] map_addr;

  assign slot_active = |cs_present_i[{slot_q, 1'b0} +: 2];
  assign slot_last   = (slot_q == SLOT_W'(SLOTS - 1));
  assign word_last   = freq_q || (word_q == 4'd15);
  assign iss_fire    = (st == S_SEND);

  function automatic logic is_delay(input seq_state_e s);
    return (s == S_DSTART) || (s == S_DPLL) || (s == S_DWORD) || (s == S_DSTAB);
  endfunction

  always_comb begin
    st_nxt = st;
    unique case (st)
      S_IDLE:   if (start_i) st_nxt = freq_mode_i ? (speed_ok(speed_i) ? S_SLOT : S_FIN) : S_DSTART;
      S_DSTART: if (tmr_exp) st_nxt = S_DPLL;
      S_DPLL:   if (tmr_exp) st_nxt = S_SLOT;
      S_SLOT: begin
        if (slot_active)    st_nxt = S_DWORD;
        else if (slot_last) st_nxt = freq_q ? S_FIN : S_DSTAB;
      end
      S_DWORD:  if (tmr_exp) st_nxt = (!freq_q && word_skipped(word_q)) ? S_NEXT : S_SEND;
      S_SEND:   st_nxt = S_ACK;
      S_ACK: begin
        if (iss_ok)       st_nxt = S_NEXT;
        else if (iss_tmo) st_nxt = S_FIN;
      end
      S_NEXT: begin
        if (!word_last)     st_nxt = S_DWORD;
        else if (slot_last) st_nxt = freq_q ? S_FIN : S_DSTAB;
        else                st_nxt = S_SLOT;
      end
      S_DSTAB:  if (tmr_exp) st_nxt = S_FIN;
      S_FIN:    st_nxt = S_IDLE;
      default:  st_nxt = S_IDLE;
    endcase
    unique case (st_nxt)
      S_DSTART: tmr_lim = dly_start_i;
      S_DPLL:   tmr_lim = dly_pll_i;
      S_DSTAB:  tmr_lim = dly_stab_i;
      default:  tmr_lim = dly_word_i;
    endcase
    tmr_load = is_delay(st_nxt) && (st_nxt != st);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      slot_q    <= '0;
      word_q    <= '0;
      freq_q    <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      err_spd_q <= 1'b0;
      err_tmo_q <= 1'b0;
      cs_q      <= '0;
      bank_q    <= '0;
      addr_q    <= '0;
    end else begin
      st     <= st_nxt;
      done_q <= 1'b0;
      unique case (st)
        S_IDLE: if (start_i) begin
          busy_q    <= 1'b1;
          err_tmo_q <= 1'b0;
          err_spd_q <= freq_mode_i && !speed_ok(speed_i);
          freq_q    <= freq_mode_i;
          slot_q    <= '0;
          word_q    <= '0;
        end
        S_SLOT: begin
          if (slot_active)     word_q <= '0;
          else if (!slot_last) slot_q <= slot_q + 1'b1;
        end
        S_SEND: begin
          cs_q   <= map_cs;
          bank_q <= map_bank;
          addr_q <= map_addr;
        end
        S_ACK: if (iss_tmo && !iss_ok) err_tmo_q <= 1'b1;
        S_NEXT: begin
          if (!word_last)      word_q <= word_q + 1'b1;
          else if (!slot_last) slot_q <= slot_q + 1'b1;
        end
        S_FIN: begin
          done_q <= 1'b1;
          busy_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  rcw_delay_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .lim_i(tmr_lim), .expired_o(tmr_exp)
  );

  rcw_cmd_issue #(.CNT_W(CNT_W)) u_issue (
    .clk(clk), .rst_n(rst_n), .fire_i(iss_fire), .ack_i(ack_i), .tmo_lim_i(tmo_lim_i),
    .send_o(send_o), .ok_o(iss_ok), .tmo_o(iss_tmo)
  );

  rcw_word_map #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)) u_map (
    .slot_i(slot_q), .word_i(word_q), .freq_i(freq_q), .speed_i(speed_i),
    .single_rank_i(single_rank_i), .rc2_i(rc2_i), .rc3_i(rc3_i), .rc4_i(rc4_i),
    .rc5_i(rc5_i), .rc8_i(rc8_i), .vdd_i(vdd_code_i),
    .cs_o(map_cs), .bank_o(map_bank), .addr_o(map_addr)
  );

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign err_speed_o = err_spd_q;
  assign err_tmo_o   = err_tmo_q;
  assign cmd_cs_o    = cs_q;
  assign cmd_bank_o  = bank_q;
  assign cmd_addr_o  = addr_q;

  AST_ONE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    send_o |-> ($countones(cmd_cs_o) == 2)); // R1
  AST_NO_SKIPPED_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    send_o |-> !(!cmd_bank_o[2] && (cmd_addr_o[2:1] == 2'b11))); // R2
  AST_ADDR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    send_o |-> (cmd_addr_o[ADDR_W-1:5] == '0)); // R4
  AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (send_o && $past(send_o)) |-> ($stable(cmd_cs_o) && $stable(cmd_bank_o) && $stable(cmd_addr_o))); // R5
  AST_SPEED_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err_speed_o |-> !send_o); // R8
  AST_TMO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err_tmo_o |-> !send_o); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !send_o); // R10
endmodule

// File: tb/tb_rcw_ctlword_seq.sv
`timescale 1ns/1ps
module tb_rcw_ctlword_seq;
  localparam int CS_N = 16, SLOTS = 8, ADDR_W = 16, CNT_W = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start_i, freq_mode_i, ack_i;
  logic [CS_N-1:0] cs_present_i;
  logic [SLOTS-1:0] single_rank_i;
  logic [4*SLOTS-1:0] rc2_i, rc3_i, rc4_i, rc5_i, rc8_i;
  logic [3:0] vdd_code_i;
  logic [2:0] speed_i;
  logic [CNT_W-1:0] dly_start_i, dly_pll_i, dly_word_i, dly_stab_i, tmo_lim_i;
  logic busy_o, done_o, err_speed_o, err_tmo_o, send_o;
  logic [CS_N-1:0] cmd_cs_o;
  logic [2:0] cmd_bank_o;
  logic [ADDR_W-1:0] cmd_addr_o;

  rcw_ctlword_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .freq_mode_i(freq_mode_i),
    .cs_present_i(cs_present_i), .single_rank_i(single_rank_i),
    .rc2_i(rc2_i), .rc3_i(rc3_i), .rc4_i(rc4_i), .rc5_i(rc5_i), .rc8_i(rc8_i),
    .vdd_code_i(vdd_code_i), .speed_i(speed_i),
    .dly_start_i(dly_start_i), .dly_pll_i(dly_pll_i), .dly_word_i(dly_word_i),
    .dly_stab_i(dly_stab_i), .tmo_lim_i(tmo_lim_i), .ack_i(ack_i),
    .busy_o(busy_o), .done_o(done_o), .err_speed_o(err_speed_o), .err_tmo_o(err_tmo_o),
    .send_o(send_o), .cmd_cs_o(cmd_cs_o), .cmd_bank_o(cmd_bank_o), .cmd_addr_o(cmd_addr_o)
  );

  int n_chk = 0, n_fail = 0;
  longint cyc = 0;
  logic [34:0] expq[$];
  bit resp_en = 1'b1;
  int resp_lat = 3;
  int n_cmd = 0;
  bit first_cmd = 1'b1;
  longint t_start = 0, first_rise = 0, last_rise = 0, last_fall = 0, t_done = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_val(input int w, input int s);
    if (w == 0) return 4'h2;
    if (w == 1) return single_rank_i[s] ? 4'hC : 4'h0;
    if (w == 2) return rc2_i[4*s +: 4];
    if (w == 3) return rc3_i[4*s +: 4];
    if (w == 4) return rc4_i[4*s +: 4];
    if (w == 5) return rc5_i[4*s +: 4];
    if (w == 8) return rc8_i[4*s +: 4];
    if (w == 9) return 4'hD;
    if (w == 11) return vdd_code_i;
    return 4'h0;
  endfunction

  function automatic logic [34:0] pack_cmd(input int s, input int w, input logic [3:0] v);
    logic [3:0] wn;
    logic [CS_N-1:0] cs;
    logic [ADDR_W-1:0] a;
    wn = 4'(w);
    cs = 16'h3 << (2 * s);
    a = '0;
    a[4] = v[1]; a[3] = v[0]; a[2:0] = wn[2:0];
    return {cs, wn[3], v[3], v[2], a};
  endfunction

  task automatic push_init(input int max_cmds);
    int pushed = 0;
    for (int s = 0; s < SLOTS; s++)
      if (cs_present_i[2*s] || cs_present_i[2*s+1])
        for (int w = 0; w < 16; w++)
          if (w != 6 && w != 7 && pushed < max_cmds) begin
            expq.push_back(pack_cmd(s, w, exp_val(w, s)));
            pushed++;
          end
  endtask

  task automatic push_freq(input logic [3:0] v);
    for (int s = 0; s < SLOTS; s++)
      if (cs_present_i[2*s] || cs_present_i[2*s+1])
        expq.push_back(pack_cmd(s, 10, v));
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // target: acknowledges a pending send after resp_lat cycles
  initial begin
    int cnt = 0;
    ack_i = 1'b0;
    forever begin
      @(negedge clk);
      if (ack_i) ack_i = 1'b0;
      else if (send_o && resp_en) begin
        cnt++;
        if (cnt >= resp_lat) begin
          ack_i = 1'b1;
          cnt = 0;
        end
      end else cnt = 0;
    end
  end

  // monitor: pops the scoreboard on each new command
  initial begin
    logic send_d = 1'b0;
    forever begin
      @(negedge clk);
      if (send_o && !send_d) begin
        logic [34:0] got;
        got = {cmd_cs_o, cmd_bank_o, cmd_addr_o};
        n_cmd++;
        if (expq.size() == 0) check(1'b0, "R2", "unexpected command", got, 0);
        else begin
          logic [34:0] e;
          e = expq.pop_front();
          check(got == e, "R1 R3 R4 R7", "command fields", got, e);
        end
        if (!first_cmd)
          check(cyc - last_rise > longint'(dly_word_i), "R6", "command spacing",
                cyc - last_rise, dly_word_i + 1);
        else first_rise = cyc;
        first_cmd = 1'b0;
        last_rise = cyc;
      end
      if (!send_o && send_d) last_fall = cyc;
      send_d = send_o;
    end
  end

  task automatic run_pass(input bit fm);
    int k = 0;
    freq_mode_i = fm;
    first_cmd = 1'b1;
    n_cmd = 0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    t_start = cyc;
    check(busy_o == 1'b1, "R10", "busy after start", busy_o, 1);
    while (!done_o && k < 20000) begin
      @(negedge clk);
      k++;
    end
    check(done_o == 1'b1, "R10", "done reached", done_o, 1);
    t_done = cyc;
    @(negedge clk);
    check(done_o == 1'b0, "R10", "done lasts one cycle", done_o, 0);
    check(busy_o == 1'b0, "R10", "busy low after done", busy_o, 0);
    check(expq.size() == 0, "R2", "expected commands left", expq.size(), 0);
    expq.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R10", "watchdog expired", 0, 1);
    if (!finished) begin
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; freq_mode_i = 1'b0;
    cs_present_i = '0; single_rank_i = '0;
    rc2_i = 32'h89AB_CDEF; rc3_i = 32'h1357_9BDF; rc4_i = 32'hF0E1_D2C3;
    rc5_i = 32'h2468_ACE0; rc8_i = 32'h5A5A_A5A5;
    vdd_code_i = 4'h5; speed_i = 3'd3;
    dly_start_i = 30; dly_pll_i = 20; dly_word_i = 10; dly_stab_i = 25; tmo_lim_i = 40;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R10)
    check(busy_o == 0 && done_o == 0, "R10", "idle after reset", {busy_o, done_o}, 0);
    check(send_o == 0, "R5", "no send after reset", send_o, 0);
    check(err_speed_o == 0 && err_tmo_o == 0, "R10", "errors clear at reset",
          {err_speed_o, err_tmo_o}, 0);

    // single populated slot, single rank
    cs_present_i = 16'h0003; single_rank_i = 8'h01;
    push_init(100);
    run_pass(1'b0);
    check(n_cmd == 14, "R2", "words sent for one slot", n_cmd, 14);
    check(first_rise - t_start >= longint'(dly_start_i + dly_pll_i + dly_word_i), "R6",
          "start to first command", first_rise - t_start, dly_start_i + dly_pll_i + dly_word_i);
    check(t_done - last_fall >= longint'(dly_stab_i), "R6", "stabilisation before done",
          t_done - last_fall, dly_stab_i);

    // two slots, each populated by one odd/even bit only
    cs_present_i = 16'h0120; single_rank_i = 8'h04; vdd_code_i = 4'hA;
    push_init(100);
    run_pass(1'b0);
    check(n_cmd == 28, "R1", "words sent for slots 2 and 4", n_cmd, 28);

    // nothing populated
    cs_present_i = 16'h0000;
    run_pass(1'b0);
    check(n_cmd == 0, "R1", "no command for empty mask", n_cmd, 0);

    // timeout: target never answers
    cs_present_i = 16'h000C; resp_en = 1'b0;
    push_init(1);
    run_pass(1'b0);
    check(n_cmd == 1, "R9", "commands before abort", n_cmd, 1);
    check(err_tmo_o == 1'b1, "R9", "timeout flag", err_tmo_o, 1);
    check(send_o == 1'b0, "R9", "send dropped", send_o, 0);
    check(last_fall - first_rise > longint'(tmo_lim_i), "R9", "send held to limit",
          last_fall - first_rise, tmo_lim_i + 1);
    resp_en = 1'b1;

    // frequency change, 1333 grade (code 3 -> value 2)
    cs_present_i = 16'h8001; speed_i = 3'd3;
    push_freq(4'd2);
    run_pass(1'b1);
    check(n_cmd == 2, "R7", "speed words sent", n_cmd, 2);
    check(err_tmo_o == 1'b0, "R10", "timeout flag cleared by start", err_tmo_o, 0);

    // frequency change, 1866 grade (code 5 -> value 4)
    cs_present_i = 16'h0030; speed_i = 3'd5;
    push_freq(4'd4);
    run_pass(1'b1);
    check(n_cmd == 1, "R7", "speed word for slot 2", n_cmd, 1);

    // unsupported speed codes
    speed_i = 3'd6;
    run_pass(1'b1);
    check(n_cmd == 0, "R8", "no command on bad speed", n_cmd, 0);
    check(err_speed_o == 1'b1, "R8", "speed error flag", err_speed_o, 1);
    speed_i = 3'd0;
    run_pass(1'b1);
    check(n_cmd == 0 && err_speed_o == 1'b1, "R8", "speed code 0 rejected",
          {n_cmd[3:0], err_speed_o}, 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule